// File: doc/BRIEF.md
# Pipelined Q1.15 Complex Multiplier

This block multiplies two complex operands, X and Y. Each operand has a real half and an imaginary half, and each half is a signed fraction in Q1.15. Four real multipliers work in parallel to form the cross products. Each product is widened to Q1.31. Two saturating adder/subtractors then combine the products into a full-width real result and a full-width imaginary result, and both results leave the block on the same clock edge.

A per-operation control selects the conjugate of Y, and it travels down the pipeline with its operands. The block has two register stages. Operands presented before one rising edge produce a result after the following edge, and a new operand set can be presented on every cycle.

Two arithmetic cases need special handling:
- Minus one times minus one does not fit in Q1.31. The multiplier that sees it returns the largest positive fraction instead of the wrapped value.
- A sum or difference can leave the 32-bit range. In that case the result is clamped and an overflow flag is raised together with the result.

Top module: `cplx_mul_q15`

## Requirements
- R1: With `conj_sel` low, `res_re` equals XR·YR − XI·YI and `res_im` equals XR·YI + XI·YR. Every product is the signed Q1.15 product shifted left one bit, giving Q1.31.
- R2: With `conj_sel` high, `res_re` equals XR·YR + XI·YI and `res_im` equals XI·YR − XR·YI.
- R3: A sum or difference above 2^31−1 gives 0x7FFFFFFF, and one below −2^31 gives 0x80000000. `res_ovf` is high in the same cycle as the result when either half was clamped, and low otherwise.
- R4: A product whose two inputs are both 0x8000 counts as 0x7FFFFFFF. For example, X = 0x8000 + j0 times Y = 0x8000 + j0 gives `res_re` = 0x7FFFFFFF and `res_im` = 0.
- R5: `res_vld` follows `in_vld` with a latency of exactly two rising edges.
- R6: A new operand set is accepted on every cycle. `conj_sel` applies only to the operands presented with it, even when it changes from one cycle to the next.
- R7: A synchronous active-high `rst` clears `res_vld`, `res_ovf`, `res_re` and `res_im` to zero. An operation that was in flight when reset was asserted produces no valid result.
- R8: While `in_vld` is low, the operand inputs have no effect. `res_vld` and `res_ovf` go low two edges later, and `res_re` and `res_im` hold the last valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operand set is valid this cycle |
| conj_sel | input | 1 | Use the conjugate of Y for this operation |
| x_re | input | DW | Real part of X, Q1.15 |
| x_im | input | DW | Imaginary part of X, Q1.15 |
| y_re | input | DW | Real part of Y, Q1.15 |
| y_im | input | DW | Imaginary part of Y, Q1.15 |
| res_vld | output | 1 | Result is valid |
| res_re | output | 2·DW | Real result, Q1.31 |
| res_im | output | 2·DW | Imaginary result, Q1.31 |
| res_ovf | output | 1 | At least one result half was saturated |

## Verification
The bench builds the block with the default DW = 16. At that width the golden model can work exactly in 64-bit integers. All of the extreme operands can be written out directly: 0x8000, 0x7FFF, and pairs of 0x8000 that trigger both the trap and saturation in each direction.

The vector table streams back to back while `conj_sel` alternates, so one run covers pipeline alignment and both conjugation modes. Directed steps after the table cover the following:
- held outputs during idle cycles;
- a reset that arrives while an operation is in flight.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
    typedef enum logic {
        COMB_ADD = 1'b0,
        COMB_SUB = 1'b1
    } comb_op_e;
endpackage

// File: rtl/cmul_prod.sv
// One real Q1.15 x Q1.15 product, widened to Q1.31, with the -1 x -1 trap.
module cmul_prod #(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0]   op_a,
    input  logic signed [DW-1:0]   op_b,
    output logic signed [2*DW-1:0] prod
);
    localparam int PW = 2 * DW;
    localparam logic [DW-1:0] MINUS_ONE = {1'b1, {(DW-1){1'b0}}};
    localparam logic [PW-1:0] MAX_POS   = {1'b0, {(PW-1){1'b1}}};

    logic signed [PW-1:0] raw;
    logic                 trap;

    always_comb begin
        raw  = op_a * op_b;
        trap = (op_a == MINUS_ONE) && (op_b == MINUS_ONE);
        prod = trap ? MAX_POS : {raw[PW-2:0], 1'b0};
    end
endmodule

// File: rtl/cmul_addsub_sat.sv
// Saturating signed adder/subtractor.
module cmul_addsub_sat
    import cmul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic signed [W-1:0] lhs,
    input  logic signed [W-1:0] rhs,
    input  comb_op_e            op,
    output logic signed [W-1:0] result,
    output logic                clamped
);
    localparam logic [W-1:0] TOP = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] BOT = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0] wide;

    always_comb begin
        if (op == COMB_SUB) wide = {lhs[W-1], lhs} - {rhs[W-1], rhs};
        else                wide = {lhs[W-1], lhs} + {rhs[W-1], rhs};
        clamped = wide[W] != wide[W-1];
        if (!clamped)     result = wide[W-1:0];
        else if (wide[W]) result = BOT;
        else              result = TOP;
    end
endmodule

// File: rtl/cplx_mul_q15.sv
module cplx_mul_q15
    import cmul_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_vld,
    input  logic                   conj_sel,
    input  logic [DW-1:0]          x_re,
    input  logic [DW-1:0]          x_im,
    input  logic [DW-1:0]          y_re,
    input  logic [DW-1:0]          y_im,
    output logic                   res_vld,
    output logic [2*DW-1:0]        res_re,
    output logic [2*DW-1:0]        res_im,
    output logic                   res_ovf
);
    localparam int PW     = 2 * DW;
    localparam int N_MUL  = 4;
    localparam int N_COMB = 2;

    typedef struct packed {
        logic          vld;
        logic          conj;
        logic [DW-1:0] xr;
        logic [DW-1:0] xi;
        logic [DW-1:0] yr;
        logic [DW-1:0] yi;
    } opnd_t;

    typedef struct packed {
        logic          vld;
        logic          ovf;
        logic [PW-1:0] re;
        logic [PW-1:0] im;
    } rslt_t;

    typedef struct packed {
        opnd_t s1;
        rslt_t s2;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    // Product slots: 0 = xr*yr, 1 = xi*yi, 2 = xr*yi, 3 = xi*yr
    logic signed [DW-1:0] mul_a [N_MUL];
    logic signed [DW-1:0] mul_b [N_MUL];
    logic signed [PW-1:0] mul_p [N_MUL];

    // Combiner slots: 0 = real, 1 = imaginary
    logic signed [PW-1:0] cmb_l   [N_COMB];
    logic signed [PW-1:0] cmb_r   [N_COMB];
    comb_op_e             cmb_op  [N_COMB];
    logic signed [PW-1:0] cmb_out [N_COMB];
    logic                 cmb_sat [N_COMB];

    always_comb begin
        mul_a[0] = pipe_q.s1.xr;  mul_b[0] = pipe_q.s1.yr;
        mul_a[1] = pipe_q.s1.xi;  mul_b[1] = pipe_q.s1.yi;
        mul_a[2] = pipe_q.s1.xr;  mul_b[2] = pipe_q.s1.yi;
        mul_a[3] = pipe_q.s1.xi;  mul_b[3] = pipe_q.s1.yr;
    end

    for (genvar m = 0; m < N_MUL; m++) begin : g_mul
        cmul_prod #(.DW(DW)) u_prod (
            .op_a (mul_a[m]),
            .op_b (mul_b[m]),
            .prod (mul_p[m])
        );
    end

    // Conjugation flips the sign of YI. Operand order is chosen so that
    // this never needs a negated input: only the operation changes.
    always_comb begin
        cmb_l[0]  = mul_p[0];
        cmb_r[0]  = mul_p[1];
        cmb_op[0] = pipe_q.s1.conj ? COMB_ADD : COMB_SUB;
        cmb_l[1]  = mul_p[3];
        cmb_r[1]  = mul_p[2];
        cmb_op[1] = pipe_q.s1.conj ? COMB_SUB : COMB_ADD;
    end

    for (genvar c = 0; c < N_COMB; c++) begin : g_comb
        cmul_addsub_sat #(.W(PW)) u_comb (
            .lhs     (cmb_l[c]),
            .rhs     (cmb_r[c]),
            .op      (cmb_op[c]),
            .result  (cmb_out[c]),
            .clamped (cmb_sat[c])
        );
    end

    always_comb begin
        pipe_d         = pipe_q;
        pipe_d.s1.vld  = in_vld;
        pipe_d.s1.conj = conj_sel;
        pipe_d.s1.xr   = x_re;
        pipe_d.s1.xi   = x_im;
        pipe_d.s1.yr   = y_re;
        pipe_d.s1.yi   = y_im;
        pipe_d.s2.vld  = pipe_q.s1.vld;
        pipe_d.s2.ovf  = 1'b0;
        if (pipe_q.s1.vld) begin
            pipe_d.s2.re  = cmb_out[0];
            pipe_d.s2.im  = cmb_out[1];
            pipe_d.s2.ovf = cmb_sat[0] | cmb_sat[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign res_vld = pipe_q.s2.vld;
    assign res_re  = pipe_q.s2.re;
    assign res_im  = pipe_q.s2.im;
    assign res_ovf = pipe_q.s2.ovf;
endmodule

// File: rtl/cplx_mul_q15_chk.sv
module cplx_mul_q15_chk #(
    parameter int DW = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            in_vld,
    input logic            conj_sel,
    input logic [DW-1:0]   x_re,
    input logic [DW-1:0]   x_im,
    input logic [DW-1:0]   y_re,
    input logic [DW-1:0]   y_im,
    input logic            res_vld,
    input logic [2*DW-1:0] res_re,
    input logic [2*DW-1:0] res_im,
    input logic            res_ovf
);
    localparam logic [DW-1:0]   MIN_IN  = {1'b1, {(DW-1){1'b0}}};
    localparam logic [2*DW-1:0] MAX_OUT = {1'b0, {(2*DW-1){1'b1}}};
    localparam logic [2*DW-1:0] MIN_OUT = {1'b1, {(2*DW-1){1'b0}}};

    logic [1:0] since_rst_q;
    always_ff @(posedge clk) begin
        if (rst)                     since_rst_q <= '0;
        else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
    end

    logic trap_in;
    assign trap_in = in_vld && x_re == MIN_IN && y_re == MIN_IN && x_im == '0 && y_im == '0;

    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        (since_rst_q >= 2'd2) |-> (res_vld == $past(in_vld, 2)));

    assert_ovf_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
        res_ovf |-> res_vld);

    assert_ovf_saturated_R3: assert property (@(posedge clk) disable iff (rst)
        res_ovf |-> (res_re == MAX_OUT || res_re == MIN_OUT ||
                     res_im == MAX_OUT || res_im == MIN_OUT));

    assert_reset_clears_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!res_vld && !res_ovf && res_re == '0 && res_im == '0));

    assert_trap_R4: assert property (@(posedge clk) disable iff (rst)
        (since_rst_q >= 2'd2 && $past(trap_in, 2)) |->
        (res_re == MAX_OUT && res_im == '0 && !res_ovf));
endmodule

bind cplx_mul_q15 cplx_mul_q15_chk #(.DW(DW)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .conj_sel (conj_sel),
    .x_re     (x_re),
    .x_im     (x_im),
    .y_re     (y_re),
    .y_im     (y_im),
    .res_vld  (res_vld),
    .res_re   (res_re),
    .res_im   (res_im),
    .res_ovf  (res_ovf)
);

// File: tb/cplx_mul_q15_tb_top.sv
`timescale 1ns/1ps
module cplx_mul_q15_tb_top;
    localparam int DW   = 16;
    localparam int NVEC = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_vld = 1'b0;
    logic          conj_sel = 1'b0;
    logic [DW-1:0] x_re = '0, x_im = '0, y_re = '0, y_im = '0;
    logic          res_vld, res_ovf;
    logic [31:0]   res_re, res_im;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cplx_mul_q15 #(.DW(DW)) dut_i (
        .clk (clk), .rst (rst), .in_vld (in_vld), .conj_sel (conj_sel),
        .x_re (x_re), .x_im (x_im), .y_re (y_re), .y_im (y_im),
        .res_vld (res_vld), .res_re (res_re), .res_im (res_im), .res_ovf (res_ovf)
    );

    // {xr, xi, yr, yi, conj}
    localparam logic [64:0] VEC [NVEC] = '{
        {16'h4000, 16'h0000, 16'h4000, 16'h0000, 1'b0},  // R1 plain
        {16'h1234, 16'hF00D, 16'h7FFF, 16'h8001, 1'b0},  // R1
        {16'h1234, 16'hF00D, 16'h7FFF, 16'h8001, 1'b1},  // R2, R6 toggle
        {16'h8000, 16'h0000, 16'h8000, 16'h0000, 1'b0},  // R4 trap
        {16'h8000, 16'h8000, 16'h8000, 16'h8000, 1'b0},  // R3 positive clamp (imag)
        {16'h8000, 16'h8000, 16'h7FFF, 16'h8000, 1'b0},  // R3 negative clamp (real)
        {16'h8000, 16'h8000, 16'h8000, 16'h7FFF, 1'b1},  // R2 + R3 clamp (imag)
        {16'h0001, 16'hFFFF, 16'hFFFF, 16'h0001, 1'b0},  // R1 tiny
        {16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 1'b1},  // R2
        {16'hA5A5, 16'h5A5A, 16'h3C3C, 16'hC3C3, 1'b1},  // R2
        {16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0}   // R1 zero
    };

    function automatic longint prod_q31(logic [15:0] a, logic [15:0] b);
        if (a == 16'h8000 && b == 16'h8000) return 64'sd2147483647;
        return longint'($signed(a)) * longint'($signed(b)) * 2;
    endfunction

    function automatic logic [32:0] clamp33(longint v);
        if (v > 64'sd2147483647)  return {1'b1, 32'h7FFFFFFF};
        if (v < -64'sd2147483648) return {1'b1, 32'h80000000};
        return {1'b0, v[31:0]};
    endfunction

    // returns {ovf, re, im}
    function automatic logic [64:0] golden(logic [64:0] v);
        logic [15:0] xr, xi, yr, yi;
        logic cj;
        longint re, im;
        logic [32:0] cr, ci;
        {xr, xi, yr, yi, cj} = v;
        if (!cj) begin
            re = prod_q31(xr, yr) - prod_q31(xi, yi);
            im = prod_q31(xr, yi) + prod_q31(xi, yr);
        end else begin
            re = prod_q31(xr, yr) + prod_q31(xi, yi);
            im = prod_q31(xi, yr) - prod_q31(xr, yi);
        end
        cr = clamp33(re);
        ci = clamp33(im);
        return {cr[32] | ci[32], cr[31:0], ci[31:0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(logic [64:0] v, logic vld);
        {x_re, x_im, y_re, y_im, conj_sel} = v;
        in_vld = vld;
    endtask

    logic done = 1'b0;

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [64:0] exp;
        logic [64:0] last_exp;
        repeat (3) @(negedge clk);
        // R7: state straight after reset
        check("R7 vld", {31'b0, res_vld}, 32'd0);
        check("R7 ovf", {31'b0, res_ovf}, 32'd0);
        check("R7 re", res_re, 32'd0);
        check("R7 im", res_im, 32'd0);
        rst = 1'b0;

        // Stream table back to back; output of vector i-2 is sampled at step i (R5, R6)
        last_exp = '0;
        for (int i = 0; i < NVEC + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                exp = golden(VEC[i-2]);
                last_exp = exp;
                check("R5 vld", {31'b0, res_vld}, 32'd1);
                check("R1/R2/R4 re", res_re, exp[63:32]);
                check("R1/R2/R4 im", res_im, exp[31:0]);
                check("R3 ovf", {31'b0, res_ovf}, {31'b0, exp[64]});
            end
            if (i < NVEC) drive(VEC[i], 1'b1);
            else          drive('0, 1'b0);
        end

        // R8: invalid inputs with live data have no effect
        drive(VEC[4], 1'b0);
        repeat (3) @(negedge clk);
        check("R8 vld", {31'b0, res_vld}, 32'd0);
        check("R8 ovf", {31'b0, res_ovf}, 32'd0);
        check("R8 re held", res_re, last_exp[63:32]);
        check("R8 im held", res_im, last_exp[31:0]);

        // R7: reset while an overflowing operation is in flight
        drive(VEC[4], 1'b1);
        @(negedge clk);
        drive('0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        check("R7 mid vld", {31'b0, res_vld}, 32'd0);
        check("R7 mid ovf", {31'b0, res_ovf}, 32'd0);
        check("R7 mid re", res_re, 32'd0);
        check("R7 mid im", res_im, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R7 flushed vld", {31'b0, res_vld}, 32'd0);
        @(negedge clk);
        check("R7 flushed vld2", {31'b0, res_vld}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule